// File: doc/BRIEF.md
# ECC address translation cache

This block turns a physical frame number into the number of the ECC page that holds the frame's tier-2 check codes. The memory controller uses it on write-back, and on reads as well when tier-2 codes are used for detection. Every lookup is tagged as read-triggered or write-triggered.

The first level is small and fully associative. It follows the TLB: when the TLB installs a page, the page is written here, and when the TLB drops a page, the entry leaves this level. The second level is larger and set associative. It is filled only with entries that leave the first level. A hit there moves the entry back into the first level.

A write-triggered lookup can miss both levels. It then takes a miss-status slot and sends a single request out of the translation port. The answer comes back through the same port. It is installed in the first level and announced on a completion output. A second miss to a frame that is already outstanding joins the slot that is open. When every slot is taken, lookups are held off. Read-triggered lookups are expected to hit the first level; a read that misses there is answered with a fault.

Top module: `ecc_xlat_cache`

## Requirements
- R1: After reset, no output is valid, `req_rdy` is 1, and a read lookup of any frame is answered with a fault one cycle after it is accepted.
- R2: A TLB install writes the frame and its ECC page into the first level. A later lookup of that frame gets `resp_vld`=1 with `resp_fault`=0 and that ECC page exactly one cycle after acceptance. In any cycle, callers present at most one of TLB install, TLB drop and fill.
- R3: A read-triggered lookup that misses the first level is answered one cycle after acceptance with `resp_vld`=1 and `resp_fault`=1, and it raises no external request.
- R4: A TLB drop moves the entry to the second level. Afterwards a read of the frame faults, and a write-triggered lookup returns the correct ECC page exactly three cycles after acceptance.
- R5: A second-level hit moves the entry back into the first level, so a following read of the frame hits in one cycle.
- R6: The first level holds 16 entries under tree pseudo-LRU. Free slots are taken lowest index first. With 17 distinct installs from reset, the first frame installed is the one displaced, and it is then served from the second level in three cycles.
- R7: A write-triggered lookup that misses both levels pulses `miss_vld` with the frame exactly three cycles after acceptance, and gives no response. A fill pulses `done_vld` with its frame and ECC page one cycle later, and installs the frame in the first level.
- R8: A write-triggered miss to a frame already outstanding raises no new `miss_vld` and gives no response.
- R9: While all 4 miss-status slots are outstanding, `req_rdy` is 0. A fill that matches a slot frees it, and `req_rdy` is 1 in the next cycle.
- R10: The second level is 8-way, indexed by the low 9 frame bits. It keeps 8 victims of one set. A ninth victim of that set replaces the oldest under tree pseudo-LRU, so that frame misses both levels.
- R11: Every non-fault response carries the ECC page last installed or filled for the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_vld | input | 1 | Lookup request valid |
| req_rdy | output | 1 | Lookup accepted this cycle if valid |
| req_pfn | input | PFN_W | Frame to translate |
| req_is_read | input | 1 | 1 read-triggered, 0 write-triggered |
| resp_vld | output | 1 | Lookup response valid |
| resp_fault | output | 1 | Read missed the first level |
| resp_epn | output | EPN_W | ECC page number |
| tlb_ins_vld | input | 1 | TLB installs a page |
| tlb_ins_pfn | input | PFN_W | Installed frame |
| tlb_ins_epn | input | EPN_W | Its ECC page |
| tlb_drop_vld | input | 1 | TLB drops a page |
| tlb_drop_pfn | input | PFN_W | Dropped frame |
| miss_vld | output | 1 | External translation request |
| miss_pfn | output | PFN_W | Frame requested |
| fill_vld | input | 1 | External translation returned |
| fill_pfn | input | PFN_W | Returned frame |
| fill_epn | input | EPN_W | Returned ECC page |
| done_vld | output | 1 | Outstanding miss resolved |
| done_pfn | output | PFN_W | Resolved frame |
| done_epn | output | EPN_W | Resolved ECC page |

## Verification
The assertions assume that TLB install, TLB drop and fill never share a cycle. They also assume that a fill is not returned in the same cycle that a merging miss for its frame is being looked up. The bench drives every input operation in a task of its own, one at a time. In the random phase it answers each external request as soon as the request appears, before it issues the next operation. Expected ECC pages come from a fixed function of the frame number, so every hit can be checked without a model of the cache contents.

// File: rtl/ecc_xlat_cache.sv
module ecc_xlat_cache #(
  parameter int PFN_W   = 28,
  parameter int EPN_W   = 24,
  parameter int L1_N    = 16,
  parameter int L2_SETS = 512,
  parameter int L2_WAYS = 8,
  parameter int MSHR_N  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_vld,
  output logic             req_rdy,
  input  logic [PFN_W-1:0] req_pfn,
  input  logic             req_is_read,
  output logic             resp_vld,
  output logic             resp_fault,
  output logic [EPN_W-1:0] resp_epn,
  input  logic             tlb_ins_vld,
  input  logic [PFN_W-1:0] tlb_ins_pfn,
  input  logic [EPN_W-1:0] tlb_ins_epn,
  input  logic             tlb_drop_vld,
  input  logic [PFN_W-1:0] tlb_drop_pfn,
  output logic             miss_vld,
  output logic [PFN_W-1:0] miss_pfn,
  input  logic             fill_vld,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic [EPN_W-1:0] fill_epn,
  output logic             done_vld,
  output logic [PFN_W-1:0] done_pfn,
  output logic [EPN_W-1:0] done_epn
);
  localparam int IW = $clog2(L1_N);
  localparam int SB = $clog2(L2_SETS);
  localparam int WB = $clog2(L2_WAYS);
  localparam int MB = $clog2(MSHR_N);
  localparam int TW = PFN_W - SB;

  typedef enum logic [1:0] {ST_IDLE, ST_S1, ST_S2} st_t;
  st_t st;

  logic             l1_v   [L1_N];
  logic [PFN_W-1:0] l1_pfn [L1_N];
  logic [EPN_W-1:0] l1_epn [L1_N];
  logic [L1_N-2:0]  l1_lru;
  logic             l2_v   [L2_SETS][L2_WAYS];
  logic [TW-1:0]    l2_tag [L2_SETS][L2_WAYS];
  logic [EPN_W-1:0] l2_epn [L2_SETS][L2_WAYS];
  logic [L2_WAYS-2:0] l2_lru [L2_SETS];
  logic             ms_v   [MSHR_N];
  logic [PFN_W-1:0] ms_pfn [MSHR_N];
  logic [PFN_W-1:0] q_pfn;

  function automatic logic [IW-1:0] l1_vic(input logic [L1_N-2:0] t);
    int n = 0;
    l1_vic = '0;
    for (int k = 0; k < IW; k++) begin
      l1_vic[IW-1-k] = t[n[IW-1:0]];
      n = 2*n + 1 + (t[n[IW-1:0]] ? 1 : 0);
    end
  endfunction
  function automatic logic [L1_N-2:0] l1_tch(input logic [L1_N-2:0] t, input logic [IW-1:0] w);
    int n = 0;
    l1_tch = t;
    for (int k = 0; k < IW; k++) begin
      l1_tch[n[IW-1:0]] = ~w[IW-1-k];
      n = 2*n + 1 + (w[IW-1-k] ? 1 : 0);
    end
  endfunction
  function automatic logic [WB-1:0] l2_vic(input logic [L2_WAYS-2:0] t);
    int n = 0;
    l2_vic = '0;
    for (int k = 0; k < WB; k++) begin
      l2_vic[WB-1-k] = t[n[WB-1:0]];
      n = 2*n + 1 + (t[n[WB-1:0]] ? 1 : 0);
    end
  endfunction
  function automatic logic [L2_WAYS-2:0] l2_tch(input logic [L2_WAYS-2:0] t, input logic [WB-1:0] w);
    int n = 0;
    l2_tch = t;
    for (int k = 0; k < WB; k++) begin
      l2_tch[n[WB-1:0]] = ~w[WB-1-k];
      n = 2*n + 1 + (w[WB-1-k] ? 1 : 0);
    end
  endfunction

  logic ms_full;
  always_comb begin
    ms_full = 1'b1;
    for (int m = 0; m < MSHR_N; m++) if (!ms_v[m]) ms_full = 1'b0;
  end
  assign req_rdy = (st == ST_IDLE) && !ms_full;
  wire accept = req_vld && req_rdy;

  // first-level searches: lookup, install target, drop target
  logic l1_hit, ins_m, ins_f, drp_m;
  logic [IW-1:0] hidx, midx, fidx, didx;
  logic [EPN_W-1:0] hepn;
  logic l2_hit;
  wire swap_go = (st == ST_S2) && l2_hit && !tlb_ins_vld && !fill_vld && !tlb_drop_vld;
  wire ins_vld = tlb_ins_vld || fill_vld || swap_go;
  logic [PFN_W-1:0] ins_pfn;
  logic [EPN_W-1:0] ins_epn, q_epn;
  always_comb begin
    ins_pfn = tlb_ins_vld ? tlb_ins_pfn : fill_vld ? fill_pfn : q_pfn;
    ins_epn = tlb_ins_vld ? tlb_ins_epn : fill_vld ? fill_epn : q_epn;
    {l1_hit, ins_m, ins_f, drp_m} = '0;
    {hidx, midx, fidx, didx} = '0;
    hepn = '0;
    for (int i = L1_N-1; i >= 0; i--) begin
      if (l1_v[i] && l1_pfn[i] == req_pfn) begin l1_hit = 1'b1; hidx = i[IW-1:0]; hepn = l1_epn[i]; end
      if (l1_v[i] && l1_pfn[i] == ins_pfn) begin ins_m = 1'b1; midx = i[IW-1:0]; end
      if (!l1_v[i]) begin ins_f = 1'b1; fidx = i[IW-1:0]; end
      if (l1_v[i] && l1_pfn[i] == tlb_drop_pfn) begin drp_m = 1'b1; didx = i[IW-1:0]; end
    end
  end
  wire [IW-1:0] slot = ins_m ? midx : ins_f ? fidx : l1_vic(l1_lru);
  wire drop_go = tlb_drop_vld && drp_m;
  wire ev_vld = drop_go || (ins_vld && !ins_m && !ins_f);
  wire [IW-1:0] ev_idx = drop_go ? didx : slot;
  wire [PFN_W-1:0] ev_pfn = l1_pfn[ev_idx];

  // second-level searches: pending lookup, stale copy of install, victim slot
  wire [SB-1:0] q_set = q_pfn[SB-1:0];
  wire [SB-1:0] i_set = ins_pfn[SB-1:0];
  wire [SB-1:0] e_set = ev_pfn[SB-1:0];
  logic inv_hit, e_free;
  logic [WB-1:0] inv_way, e_fway;
  always_comb begin
    {l2_hit, inv_hit, e_free} = '0;
    {inv_way, e_fway} = '0;
    q_epn = '0;
    for (int w = L2_WAYS-1; w >= 0; w--) begin
      if (l2_v[q_set][w] && l2_tag[q_set][w] == q_pfn[PFN_W-1:SB]) begin l2_hit = 1'b1; q_epn = l2_epn[q_set][w]; end
      if (l2_v[i_set][w] && l2_tag[i_set][w] == ins_pfn[PFN_W-1:SB]) begin inv_hit = 1'b1; inv_way = w[WB-1:0]; end
      if (!l2_v[e_set][w]) begin e_free = 1'b1; e_fway = w[WB-1:0]; end
    end
  end
  wire [WB-1:0] e_way = e_free ? e_fway : l2_vic(l2_lru[e_set]);

  logic ms_hit, ms_any;
  logic [MB-1:0] ms_free;
  always_comb begin
    ms_hit = 1'b0; ms_any = 1'b0; ms_free = '0;
    for (int m = MSHR_N-1; m >= 0; m--) begin
      if (ms_v[m] && ms_pfn[m] == q_pfn) ms_hit = 1'b1;
      if (!ms_v[m]) begin ms_any = 1'b1; ms_free = m[MB-1:0]; end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < L1_N; i++) l1_v[i] <= 1'b0;
      l1_lru <= '0;
      for (int s = 0; s < L2_SETS; s++) begin
        l2_lru[s] <= '0;
        for (int w = 0; w < L2_WAYS; w++) l2_v[s][w] <= 1'b0;
      end
    end else begin
      if (drop_go) l1_v[didx] <= 1'b0;
      if (ins_vld) begin
        l1_v[slot] <= 1'b1; l1_pfn[slot] <= ins_pfn; l1_epn[slot] <= ins_epn;
        l1_lru <= l1_tch(l1_lru, slot);
        if (inv_hit) l2_v[i_set][inv_way] <= 1'b0;
      end else if (accept && l1_hit) l1_lru <= l1_tch(l1_lru, hidx);
      if (ev_vld) begin
        l2_v[e_set][e_way] <= 1'b1;
        l2_tag[e_set][e_way] <= ev_pfn[PFN_W-1:SB];
        l2_epn[e_set][e_way] <= l1_epn[ev_idx];
        l2_lru[e_set] <= l2_tch(l2_lru[e_set], e_way);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; q_pfn <= '0;
      {resp_vld, resp_fault, miss_vld, done_vld} <= '0;
      resp_epn <= '0; miss_pfn <= '0; done_pfn <= '0; done_epn <= '0;
      for (int m = 0; m < MSHR_N; m++) begin ms_v[m] <= 1'b0; ms_pfn[m] <= '0; end
    end else begin
      resp_vld <= 1'b0; miss_vld <= 1'b0; done_vld <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          if (l1_hit || req_is_read) begin
            resp_vld <= 1'b1; resp_fault <= !l1_hit; resp_epn <= l1_hit ? hepn : '0;
          end else begin
            st <= ST_S1; q_pfn <= req_pfn;
          end
        end
        ST_S1: st <= ST_S2;
        default: begin
          st <= ST_IDLE;
          if (l2_hit) begin
            resp_vld <= 1'b1; resp_fault <= 1'b0; resp_epn <= q_epn;
          end else if (!ms_hit && ms_any) begin
            ms_v[ms_free] <= 1'b1; ms_pfn[ms_free] <= q_pfn;
            miss_vld <= 1'b1; miss_pfn <= q_pfn;
          end
        end
      endcase
      if (fill_vld) begin
        for (int m = 0; m < MSHR_N; m++) if (ms_v[m] && ms_pfn[m] == fill_pfn) ms_v[m] <= 1'b0;
        done_vld <= 1'b1; done_pfn <= fill_pfn; done_epn <= fill_epn;
      end
    end
  end

  assert_one_writer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tlb_ins_vld, tlb_drop_vld, fill_vld}));
  assert_l1_hit_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && l1_hit) |=> (resp_vld && !resp_fault));
  assert_read_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_is_read && !l1_hit) |=> (resp_vld && resp_fault && !miss_vld));
  assert_l2_not_early_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_is_read && !l1_hit) |=> (!resp_vld && !miss_vld && !req_rdy));
  assert_miss_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    miss_vld |=> !miss_vld);
  assert_done_after_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld |-> $past(fill_vld));
endmodule

// File: tb/ecc_xlat_cache_tb_top.sv
module ecc_xlat_cache_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_vld = 0, req_is_read = 0, tlb_ins_vld = 0, tlb_drop_vld = 0, fill_vld = 0;
  logic [27:0] req_pfn = '0, tlb_ins_pfn = '0, tlb_drop_pfn = '0, fill_pfn = '0;
  logic [23:0] tlb_ins_epn = '0, fill_epn = '0;
  logic req_rdy, resp_vld, resp_fault, miss_vld, done_vld;
  logic [23:0] resp_epn, done_epn;
  logic [27:0] miss_pfn, done_pfn;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  ecc_xlat_cache dut_i (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_rdy(req_rdy), .req_pfn(req_pfn),
    .req_is_read(req_is_read), .resp_vld(resp_vld), .resp_fault(resp_fault), .resp_epn(resp_epn),
    .tlb_ins_vld(tlb_ins_vld), .tlb_ins_pfn(tlb_ins_pfn), .tlb_ins_epn(tlb_ins_epn),
    .tlb_drop_vld(tlb_drop_vld), .tlb_drop_pfn(tlb_drop_pfn), .miss_vld(miss_vld),
    .miss_pfn(miss_pfn), .fill_vld(fill_vld), .fill_pfn(fill_pfn), .fill_epn(fill_epn),
    .done_vld(done_vld), .done_pfn(done_pfn), .done_epn(done_epn));

  function automatic logic [23:0] epn_of(input logic [27:0] p);
    return p[23:0] * 24'd7 + 24'h35 + {20'd0, p[27:24]};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1; @(negedge clk);
  endtask

  task automatic ins(input logic [27:0] p);
    tlb_ins_vld = 1; tlb_ins_pfn = p; tlb_ins_epn = epn_of(p); @(negedge clk); tlb_ins_vld = 0;
  endtask

  task automatic drop(input logic [27:0] p);
    tlb_drop_vld = 1; tlb_drop_pfn = p; @(negedge clk); tlb_drop_vld = 0;
  endtask

  task automatic fill(input logic [27:0] p, input string req);
    fill_vld = 1; fill_pfn = p; fill_epn = epn_of(p); @(negedge clk); fill_vld = 0;
    chk(done_vld && done_pfn == p && done_epn == epn_of(p), req, done_epn, epn_of(p));
  endtask

  // kind: 0 nothing, 1 response, 2 fault, 3 external request
  task automatic look(input logic [27:0] p, input bit rd, output int lat, output int kind, output logic [23:0] e);
    int w = 0;
    while (!req_rdy && w < 100) begin @(negedge clk); w++; end
    req_vld = 1; req_pfn = p; req_is_read = rd; @(negedge clk); req_vld = 0;
    lat = 0; kind = 0; e = '0;
    for (int c = 1; c <= 5; c++) begin
      if (kind == 0) begin
        if (resp_vld) begin lat = c; kind = resp_fault ? 2 : 1; e = resp_epn; end
        else if (miss_vld) begin lat = c; kind = 3; e = {miss_pfn == p, 23'd0}; end
      end
      if (c < 5) @(negedge clk);
    end
  endtask

  int lat, kind;
  logic [23:0] e;
  logic [27:0] p;
  bit finished = 0;

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd77));
    do_reset();
    chk(!resp_vld && !miss_vld && !done_vld && req_rdy, "R1 reset outputs", {resp_vld, miss_vld, done_vld, req_rdy}, 4'b0001);
    look(28'h123, 1, lat, kind, e);
    chk(kind == 2 && lat == 1, "R1 empty read faults", kind*10+lat, 21);

    ins(28'h40);
    look(28'h40, 1, lat, kind, e);
    chk(kind == 1 && lat == 1 && e == epn_of(28'h40), "R2 read hit", e, epn_of(28'h40));
    look(28'h40, 0, lat, kind, e);
    chk(kind == 1 && lat == 1 && e == epn_of(28'h40), "R2 write hit", kind*10+lat, 11);
    look(28'h41, 1, lat, kind, e);
    chk(kind == 2 && lat == 1, "R3 read miss fault", kind*10+lat, 21);

    drop(28'h40);
    look(28'h40, 1, lat, kind, e);
    chk(kind == 2 && lat == 1, "R4 read after drop", kind*10+lat, 21);
    look(28'h40, 0, lat, kind, e);
    chk(kind == 1 && lat == 3 && e == epn_of(28'h40), "R4 second level hit", kind*10+lat, 13);
    look(28'h40, 1, lat, kind, e);
    chk(kind == 1 && lat == 1, "R5 swapped back", kind*10+lat, 11);

    do_reset();
    for (int i = 0; i < 17; i++) ins(28'h1000 + 28'(i));
    look(28'h1000, 1, lat, kind, e);
    chk(kind == 2, "R6 first install displaced", kind, 2);
    look(28'h1010, 1, lat, kind, e);
    chk(kind == 1 && lat == 1, "R6 newest present", kind*10+lat, 11);
    look(28'h1000, 0, lat, kind, e);
    chk(kind == 1 && lat == 3 && e == epn_of(28'h1000), "R6 victim from second level", kind*10+lat, 13);

    do_reset();
    look(28'h777, 0, lat, kind, e);
    chk(kind == 3 && lat == 3 && e[23], "R7 external request", kind*10+lat, 33);
    look(28'h777, 0, lat, kind, e);
    chk(kind == 0, "R8 merged miss silent", kind, 0);
    fill(28'h777, "R7 done on fill");
    look(28'h777, 1, lat, kind, e);
    chk(kind == 1 && lat == 1 && e == epn_of(28'h777), "R7 fill installed", e, epn_of(28'h777));

    for (int i = 0; i < 4; i++) begin
      look(28'h2000 + 28'(i), 0, lat, kind, e);
      chk(kind == 3, "R9 slot taken", kind, 3);
    end
    chk(!req_rdy, "R9 stall when full", req_rdy, 0);
    fill(28'h2000, "R9 fill");
    chk(req_rdy, "R9 ready after fill", req_rdy, 1);
    for (int i = 1; i < 4; i++) fill(28'h2000 + 28'(i), "R9 fill rest");

    do_reset();
    for (int i = 0; i < 9; i++) begin
      ins(28'h5 + 28'(i) * 28'd512); drop(28'h5 + 28'(i) * 28'd512);
    end
    look(28'h5, 0, lat, kind, e);
    chk(kind == 3, "R10 oldest victim gone", kind, 3);
    fill(28'h5, "R10 fill");
    look(28'h5 + 28'd512, 0, lat, kind, e);
    chk(kind == 1 && lat == 3, "R10 second victim kept", kind*10+lat, 13);
    look(28'h5 + 28'd8*28'd512, 0, lat, kind, e);
    chk(kind == 1 && lat == 3, "R10 ninth victim kept", kind*10+lat, 13);

    do_reset();
    for (int n = 0; n < 400; n++) begin
      p = (28'($urandom % 6) << 9) | 28'($urandom % 8);
      case ($urandom % 4)
        0: ins(p);
        1: drop(p);
        default: begin
          look(p, 1'($urandom % 2), lat, kind, e);
          if (kind == 1) chk(e == epn_of(p), "R11 random page", e, epn_of(p));
          else if (kind == 3) fill(p, "R11 random fill");
          else chk(kind == 2 || kind == 3, "R11 random answered", kind, 1);
        end
      endcase
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule